// File: doc/BRIEF.md
# Sample-Clock Source Lock and Slip Monitor

This block watches eleven external sample-clock sources and folds their state into a single 32-bit status word for a register file. Each source supplies a lock level, which may come from a foreign clock domain, and a slip pulse in the local domain. The lock half of the word always shows the live, synchronized lock state. The slip half records sticky error flags. A quadlet-sized read of the word clears these flags. A block-sized read only observes them.

The block also resolves the 4-bit code of the currently selected clock source into a single "selected source locked" flag. It emits two one-cycle event pulses for the notification logic. The first fires when any lock bit changes. The second fires when the selected-source locked flag changes. Slip errors never raise an event. Clock recovery itself is not part of this block.

Top module: `clksrc_lock_monitor`

## Requirements
- R1: After reset, with select code 0, the status word is all zeros and both event outputs and the selected-locked flag are 0.
- R2: Lock bits sit in status bits 10:0. Bit 0 is AES1, bits 1 to 3 are AES2 to AES4, bit 4 is ADAT, bit 5 is TDIF, bits 6 to 9 are ARX1 to ARX4 and bit 10 is word clock. Each lock bit follows its input after a two-flop synchronizer, so a change driven before edge N shows after edge N+1 and not after edge N. Bits 15:11 and 31:27 always read 0.
- R3: A slip pulse on source i, present at a clock edge, sets status bit 16+i after that edge. Bits 26:16 use the same source order as the lock bits. A set bit stays set until a clearing read.
- R4: A read with quadlet qualifier high (rd_stb_i=1, rd_quad_i=1) sees the current slip bits on status_o in the read cycle, and those bits are clear after the edge that ends the read.
- R5: A block read (rd_stb_i=1, rd_quad_i=0) leaves the slip bits unchanged.
- R6: A slip pulse in the same cycle as a clearing quadlet read leaves its own bit set after the read, while the other slip bits clear.
- R7: any_lock_evt_o is high for exactly the one cycle in which the visible lock bits differ from their value one cycle earlier. Slip pulses and selection changes do not raise it.
- R8: Select codes 0 to 3 choose AES1 to AES4, 5 chooses ADAT, 6 chooses TDIF, 7 chooses word clock, and 8 to 11 choose ARX1 to ARX4. sel_locked_o equals the chosen lock bit. Codes 13 to 15 report unlocked.
- R9: Select code 12 (internal) always reports locked. Code 4 (any AES) reports locked when at least one of lock bits 3:0 is set.
- R10: sel_lock_evt_o is high for one cycle whenever sel_locked_o differs from its value in the previous cycle, whether a lock change or a selection change caused it. A lock change on an unselected source does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_async_i | input | 11 | Per-source lock levels, any clock domain |
| slip_pulse_i | input | 11 | Per-source slip pulses, local clock domain |
| sel_src_i | input | 4 | Code of the currently selected clock source |
| rd_stb_i | input | 1 | Status register read strobe |
| rd_quad_i | input | 1 | 1 = quadlet-sized read (clears slips), 0 = block read |
| status_o | output | 32 | Extended status word: lock bits 10:0, slip bits 26:16 |
| sel_locked_o | output | 1 | Selected clock source is locked |
| any_lock_evt_o | output | 1 | One-cycle pulse on any lock bit change |
| sel_lock_evt_o | output | 1 | One-cycle pulse on a change of sel_locked_o |

## Verification
A stale previous-lock register shows at once as an event pulse that lasts too long, or is missing, in the cycle after a lock bit moves. A wrong slip register shows on status_o in the cycle after a slip or a read: a lost bit, a bit that survives a quadlet read, or a bit dropped by a block read. Errors in select decoding show directly on sel_locked_o in the same cycle as the select code is applied. A stage missing from the synchronizer shows as lock bits one edge early.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  localparam int NUM_SRC  = 11;
  localparam int SEL_W    = 4;
  localparam int STAT_W   = 32;
  localparam int SLIP_LSB = 16;
  localparam int SLIP_MSB = SLIP_LSB + NUM_SRC - 1;

  // bit positions of each source inside the lock / slip fields
  localparam int POS_AES1 = 0;
  localparam int POS_AES2 = 1;
  localparam int POS_AES3 = 2;
  localparam int POS_AES4 = 3;
  localparam int POS_ADAT = 4;
  localparam int POS_TDIF = 5;
  localparam int POS_ARX1 = 6;
  localparam int POS_ARX2 = 7;
  localparam int POS_ARX3 = 8;
  localparam int POS_ARX4 = 9;
  localparam int POS_WCLK = 10;

  typedef enum logic [SEL_W-1:0] {
    SEL_AES1    = 4'd0,
    SEL_AES2    = 4'd1,
    SEL_AES3    = 4'd2,
    SEL_AES4    = 4'd3,
    SEL_AES_ANY = 4'd4,
    SEL_ADAT    = 4'd5,
    SEL_TDIF    = 4'd6,
    SEL_WCLK    = 4'd7,
    SEL_ARX1    = 4'd8,
    SEL_ARX2    = 4'd9,
    SEL_ARX3    = 4'd10,
    SEL_ARX4    = 4'd11,
    SEL_INT     = 4'd12
  } sel_code_e;

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/clksrc_slip_sticky.sv
module clksrc_slip_sticky #(
  parameter int WIDTH = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] flags_o
);

  logic [WIDTH-1:0] flags_q;
  logic [WIDTH-1:0] flags_d;
  logic             flags_en;

  // a new slip wins over a clear landing in the same cycle
  always_comb begin
    flags_en = clr_i | (|set_i);
    flags_d  = set_i | (flags_q & ~{WIDTH{clr_i}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/clksrc_sel_decode.sv
module clksrc_sel_decode
  import clksrc_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] lock_i,
  output logic               locked_o
);

  always_comb begin
    case (sel_i)
      SEL_AES1:    locked_o = lock_i[POS_AES1];
      SEL_AES2:    locked_o = lock_i[POS_AES2];
      SEL_AES3:    locked_o = lock_i[POS_AES3];
      SEL_AES4:    locked_o = lock_i[POS_AES4];
      SEL_AES_ANY: locked_o = |lock_i[POS_AES4:POS_AES1];
      SEL_ADAT:    locked_o = lock_i[POS_ADAT];
      SEL_TDIF:    locked_o = lock_i[POS_TDIF];
      SEL_WCLK:    locked_o = lock_i[POS_WCLK];
      SEL_ARX1:    locked_o = lock_i[POS_ARX1];
      SEL_ARX2:    locked_o = lock_i[POS_ARX2];
      SEL_ARX3:    locked_o = lock_i[POS_ARX3];
      SEL_ARX4:    locked_o = lock_i[POS_ARX4];
      SEL_INT:     locked_o = 1'b1;
      default:     locked_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/clksrc_lock_monitor.sv
module clksrc_lock_monitor
  import clksrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lock_async_i,
  input  logic [NUM_SRC-1:0] slip_pulse_i,
  input  logic [SEL_W-1:0]   sel_src_i,
  input  logic               rd_stb_i,
  input  logic               rd_quad_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               sel_locked_o,
  output logic               any_lock_evt_o,
  output logic               sel_lock_evt_o
);

  logic [NUM_SRC-1:0] lock_sync;
  logic [NUM_SRC-1:0] lock_prev_q;
  logic [NUM_SRC-1:0] slip_flags;
  logic               slip_clr;
  logic               sel_locked;
  logic               sel_prev_q;

  clksrc_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lock_async_i),
    .q_o    (lock_sync)
  );

  assign slip_clr = rd_stb_i & rd_quad_i;

  clksrc_slip_sticky #(
    .WIDTH (NUM_SRC)
  ) u_slip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (slip_pulse_i),
    .clr_i   (slip_clr),
    .flags_o (slip_flags)
  );

  clksrc_sel_decode u_dec (
    .sel_i    (sel_src_i),
    .lock_i   (lock_sync),
    .locked_o (sel_locked)
  );

  // history registers for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_prev_q <= '0;
      sel_prev_q  <= 1'b0;
    end else begin
      lock_prev_q <= lock_sync;
      sel_prev_q  <= sel_locked;
    end
  end

  always_comb begin
    status_o                    = '0;
    status_o[NUM_SRC-1:0]       = lock_sync;
    status_o[SLIP_MSB:SLIP_LSB] = slip_flags;
    sel_locked_o                = sel_locked;
    any_lock_evt_o              = |(lock_sync ^ lock_prev_q);
    sel_lock_evt_o              = sel_locked ^ sel_prev_q;
  end

endmodule

// File: rtl/clksrc_lock_monitor_chk.sv
module clksrc_lock_monitor_chk
  import clksrc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] slip_pulse_i,
  input logic [SEL_W-1:0]   sel_src_i,
  input logic               rd_stb_i,
  input logic               rd_quad_i,
  input logic [STAT_W-1:0]  status_o,
  input logic               sel_locked_o,
  input logic               any_lock_evt_o,
  input logic               sel_lock_evt_o
);

  logic [NUM_SRC-1:0] lock_f;
  logic [NUM_SRC-1:0] slip_f;
  assign lock_f = status_o[NUM_SRC-1:0];
  assign slip_f = status_o[SLIP_MSB:SLIP_LSB];

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[SLIP_LSB-1:NUM_SRC] == '0 && status_o[STAT_W-1:SLIP_MSB+1] == '0);

  a_r3_slip_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slip_pulse_i) |=> ((slip_f & $past(slip_pulse_i)) == $past(slip_pulse_i)));

  a_r5_sticky_without_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && rd_quad_i) |=> (($past(slip_f) & ~slip_f) == '0));

  a_r6_clear_keeps_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && rd_quad_i) |=> (slip_f == $past(slip_pulse_i)));

  a_r7_evt_only_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_lock_evt_o |-> (lock_f != $past(lock_f)));

  a_r7_change_gives_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_f != $past(lock_f)) |-> any_lock_evt_o);

  a_r9_internal_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_src_i == SEL_INT) |-> sel_locked_o);

  a_r9_any_aes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_src_i == SEL_AES_ANY) |-> (sel_locked_o == (|lock_f[POS_AES4:POS_AES1])));

  a_r10_sel_evt_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lock_evt_o |-> (sel_locked_o != $past(sel_locked_o)));

endmodule

bind clksrc_lock_monitor clksrc_lock_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .slip_pulse_i   (slip_pulse_i),
  .sel_src_i      (sel_src_i),
  .rd_stb_i       (rd_stb_i),
  .rd_quad_i      (rd_quad_i),
  .status_o       (status_o),
  .sel_locked_o   (sel_locked_o),
  .any_lock_evt_o (any_lock_evt_o),
  .sel_lock_evt_o (sel_lock_evt_o)
);

// File: tb/clksrc_lock_monitor_bench.sv
module clksrc_lock_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] lock_in;
  logic [10:0] slip_in;
  logic [3:0]  sel;
  logic        rd_stb;
  logic        rd_quad;
  logic [31:0] status;
  logic        sel_locked;
  logic        any_evt;
  logic        sel_evt;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clksrc_lock_monitor u_clksrc_lock_monitor (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lock_async_i   (lock_in),
    .slip_pulse_i   (slip_in),
    .sel_src_i      (sel),
    .rd_stb_i       (rd_stb),
    .rd_quad_i      (rd_quad),
    .status_o       (status),
    .sel_locked_o   (sel_locked),
    .any_lock_evt_o (any_evt),
    .sel_lock_evt_o (sel_evt)
  );

  // {select code, lock pattern, expected selected-locked}
  localparam logic [15:0] VEC [18] = '{
    {4'd0,  11'h001, 1'b1}, {4'd0,  11'h7FE, 1'b0}, {4'd1,  11'h002, 1'b1},
    {4'd3,  11'h008, 1'b1}, {4'd3,  11'h7F7, 1'b0}, {4'd4,  11'h000, 1'b0},
    {4'd4,  11'h004, 1'b1}, {4'd5,  11'h010, 1'b1}, {4'd5,  11'h7EF, 1'b0},
    {4'd6,  11'h020, 1'b1}, {4'd7,  11'h400, 1'b1}, {4'd7,  11'h3FF, 1'b0},
    {4'd8,  11'h040, 1'b1}, {4'd11, 11'h200, 1'b1}, {4'd11, 11'h1FF, 1'b0},
    {4'd12, 11'h000, 1'b1}, {4'd13, 11'h7FF, 1'b0}, {4'd15, 11'h7FF, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lock_in = '0; slip_in = '0; sel = 4'd0; rd_stb = 1'b0; rd_quad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check(status == 32'h0, "R1 status", status, 32'h0);
    check({sel_locked, any_evt, sel_evt} == 3'b000, "R1 flags",
          {29'h0, sel_locked, any_evt, sel_evt}, 32'h0);

    // R8 R9 table walk
    for (int i = 0; i < 18; i++) begin
      sel     = VEC[i][15:12];
      lock_in = VEC[i][11:1];
      repeat (3) tick();
      check(status[10:0] == VEC[i][11:1], "R2 lock bits", {21'h0, status[10:0]},
            {21'h0, VEC[i][11:1]});
      check(sel_locked == VEC[i][0], "R8/R9 selected lock", {31'h0, sel_locked},
            {31'h0, VEC[i][0]});
    end

    // settle: AES1 selected, nothing locked
    sel = 4'd0; lock_in = '0;
    repeat (4) tick();

    // R2 latency, R7 and R10 pulses
    lock_in = 11'h001;
    tick();
    check(status[10:0] == 11'h000, "R2 not yet visible", {21'h0, status[10:0]}, 32'h0);
    check(any_evt == 1'b0, "R7 early", {31'h0, any_evt}, 32'h0);
    tick();
    check(status[10:0] == 11'h001, "R2 visible", {21'h0, status[10:0]}, 32'h1);
    check(any_evt == 1'b1, "R7 pulse", {31'h0, any_evt}, 32'h1);
    check(sel_evt == 1'b1 && sel_locked == 1'b1, "R10 pulse",
          {30'h0, sel_evt, sel_locked}, 32'h3);
    tick();
    check(any_evt == 1'b0, "R7 one cycle", {31'h0, any_evt}, 32'h0);
    check(sel_evt == 1'b0, "R10 one cycle", {31'h0, sel_evt}, 32'h0);

    // R10 selection change, R7 no event
    sel = 4'd1;
    #1;
    check(sel_locked == 1'b0 && sel_evt == 1'b1, "R10 select change",
          {30'h0, sel_locked, sel_evt}, 32'h1);
    tick();
    check(sel_evt == 1'b0 && any_evt == 1'b0, "R7/R10 after select",
          {30'h0, sel_evt, any_evt}, 32'h0);

    // unselected source locks: R7 yes, R10 no
    lock_in = 11'h011;
    repeat (2) tick();
    check(any_evt == 1'b1 && sel_evt == 1'b0, "R10 unselected change",
          {30'h0, any_evt, sel_evt}, 32'h2);
    tick();

    // R3 slip set, no event
    slip_in = 11'h008;
    tick();
    slip_in = '0;
    check(status[26:16] == 11'h008, "R3 slip set", {21'h0, status[26:16]}, 32'h8);
    check(any_evt == 1'b0 && sel_evt == 1'b0, "R7 slip no event",
          {30'h0, any_evt, sel_evt}, 32'h0);
    tick();
    check(status[26:16] == 11'h008, "R3 sticky", {21'h0, status[26:16]}, 32'h8);

    // R5 block read keeps
    rd_stb = 1'b1; rd_quad = 1'b0;
    tick();
    rd_stb = 1'b0;
    check(status[26:16] == 11'h008, "R5 block read", {21'h0, status[26:16]}, 32'h8);

    // R4 quadlet read returns then clears
    rd_stb = 1'b1; rd_quad = 1'b1;
    #1;
    check(status[26:16] == 11'h008, "R4 read value", {21'h0, status[26:16]}, 32'h8);
    tick();
    rd_stb = 1'b0; rd_quad = 1'b0;
    check(status[26:16] == 11'h000, "R4 cleared", {21'h0, status[26:16]}, 32'h0);

    // R6 slip coincident with clear
    slip_in = 11'h402;
    tick();
    slip_in = 11'h001; rd_stb = 1'b1; rd_quad = 1'b1;
    tick();
    slip_in = '0; rd_stb = 1'b0; rd_quad = 1'b0;
    check(status[26:16] == 11'h001, "R6 new slip kept", {21'h0, status[26:16]}, 32'h1);
    check(status[15:11] == 5'h0 && status[31:27] == 5'h0, "R2 reserved",
          status & 32'hF800F800, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule